// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only three-wire serial slave that loads a bank of 16-bit configuration registers. A host pulls the active-low select down, then clocks 24-bit frames in on the serial data wire, most significant bit first. Each frame holds an 8-bit register address and then 16 bits of register data. Every 24th rising serial clock edge inside one select-low period commits the assembled frame, so several frames can follow one another under a single select.

The three serial wires and an external power-down pulse input are sampled by the block's system clock through a synchronizer, and serial clock edges are detected in that domain. A completed frame reaches the register bank as a single-cycle write strobe. A self-clearing soft reset bit in the register map restores every register to its default. A status output reports that a power-down initialization has been done, meaning power-down went high and then low, either through the register bit or through the external input.

Top module: `scfg_port`

## Requirements
- R1: After the synchronous reset `rst`, every configuration register reads 0x0000 on `cfg_regs` and `pd_init_done` is 0.
- R2: A frame is 24 bits sent MSB first: address bits 7..0, then data bits 15..0. Register n appears on `cfg_regs[16*n +: 16]`, and a frame with address n (n < 16) loads its data there.
- R3: Several complete 24-bit frames sent under one select-low period are each written to their own addresses.
- R4: Bits that remain after the last complete frame when select rises cause no write.
- R5: Serial clock edges while `cs_n` is high shift nothing and write nothing.
- R6: Select going high clears the partial frame, so the next select-low period starts a fresh 24-bit frame.
- R7: Frames addressed at 0x10 or above leave every register unchanged.
- R8: Writing address 0x00 with data bit 0 set resets every register to 0x0000, and bit 0 reads back 0. Writing address 0x00 with bit 0 clear stores the data like any other register.
- R9: Register 0x0F bit 9 is the power-down bit. `pd_init_done` rises once this bit has been 1 and then 0, stays 0 while the bit is only high, and then stays 1 until `rst`.
- R10: A high-then-low pulse on `pd_in` also sets `pd_init_done`.
- R11: A written value appears on `cfg_regs` on the 4th system clock rising edge after the 24th serial clock rise, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdata | input | 1 | Serial data, captured on sclk rise |
| pd_in | input | 1 | External power-down pulse input |
| cfg_regs | output | 256 | All registers; register n at bits 16n+15..16n |
| pd_init_done | output | 1 | Power-down high-then-low has been seen |

## Verification
A written value is due on the 4th clk rising edge after the serial clock rise that carries the last data bit: two synchronizer stages, one edge-detect and strobe stage, and one register write. The bench drives every input at clock falling edges and samples at later falling edges. In one frame it checks the old value after three rising edges and the new value after the fourth. The power-down status needs one more edge after its level falls, and pd_in takes two more for the synchronizer, so those checks are made several idle cycles later. Checks of unchanged registers are made only after the serial clock high phase has lasted long enough for any write to have landed.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int SCFG_ADDR_W   = 8;
  localparam int SCFG_DATA_W   = 16;
  localparam int SCFG_NUM_REGS = 16;
  // positions of the synchronized inputs in the synchronizer vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDAT = 2;
  localparam int PIN_PD   = 3;
  localparam int PIN_CNT  = 4;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= RST_VAL;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic               sclk_d;
  logic [FRAME_W-2:0] sh;
  logic               rise;

  assign rise = sclk_s & ~sclk_d & ~cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sh      <= '0;
      bit_cnt <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sclk_d <= sclk_s;
      wr_stb <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        sh      <= '0;
      end else if (rise) begin
        if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
          bit_cnt            <= '0;
          {wr_addr, wr_data} <= {sh, sdata_s};
          wr_stb             <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= {sh[FRAME_W-3:0], sdata_s};
        end
      end
    end
  end
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int RST_ADDR = 0,
  parameter int RST_BIT  = 0,
  parameter int PD_ADDR  = 15,
  parameter int PD_BIT   = 9,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       pd_ext,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  output logic                       pd_init_done
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              mapped;
  logic [IDX_W-1:0]  idx;
  logic              pd_lvl;
  logic              pd_prev;

  assign mapped = int'(wr_addr) < NUM_REGS;
  assign idx    = wr_addr[IDX_W-1:0];
  assign pd_lvl = regs[PD_ADDR][PD_BIT] | pd_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      pd_prev      <= 1'b0;
      pd_init_done <= 1'b0;
    end else begin
      pd_prev <= pd_lvl;
      if (pd_prev && !pd_lvl) pd_init_done <= 1'b1;
      if (wr_stb && mapped) begin
        if (int'(idx) == RST_ADDR && wr_data[RST_BIT]) begin
          for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else begin
          regs[idx] <= wr_data;
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_flat
    assign cfg_regs[n*DATA_W +: DATA_W] = regs[n];
  end
endmodule

// File: rtl/scfg_port.sv
module scfg_port
  import scfg_pkg::*;
#(
  parameter int ADDR_W      = SCFG_ADDR_W,
  parameter int DATA_W      = SCFG_DATA_W,
  parameter int NUM_REGS    = SCFG_NUM_REGS,
  parameter int RST_ADDR    = 0,
  parameter int RST_BIT     = 0,
  parameter int PD_ADDR     = 15,
  parameter int PD_BIT      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W    = ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdata,
  input  logic                       pd_in,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  output logic                       pd_init_done
);
  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic               cs_s;
  logic               wr_stb;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic [CNT_W-1:0]   bit_cnt;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_SDAT] = sdata;
    pins_raw[PIN_PD]   = pd_in;
  end

  scfg_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_CNT'(1) << PIN_CS)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign cs_s = pins_s[PIN_CS];

  scfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (cs_s),
    .sclk_s (pins_s[PIN_SCLK]),
    .sdata_s(pins_s[PIN_SDAT]),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .bit_cnt(bit_cnt)
  );

  scfg_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .RST_ADDR(RST_ADDR), .RST_BIT(RST_BIT),
    .PD_ADDR(PD_ADDR), .PD_BIT(PD_BIT)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pd_ext      (pins_s[PIN_PD]),
    .cfg_regs    (cfg_regs),
    .pd_init_done(pd_init_done)
  );
endmodule

// File: rtl/scfg_port_chk.sv
module scfg_port_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_s,
  input logic                       wr_stb,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  input logic                       pd_init_done
);
  // R2: an ordinary mapped write lands its data in the addressed slot
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && int'(wr_addr) < NUM_REGS && wr_addr != '0)
    |=> cfg_regs[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data));

  // R3: each frame produces one single-cycle strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R6: select high holds the frame counter at zero
  a_r6_cs_clears: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> bit_cnt == '0);

  // R7: unmapped addresses leave the bank untouched
  a_r7_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && int'(wr_addr) >= NUM_REGS) |=> $stable(cfg_regs));

  // R5: without a strobe no register moves
  a_r5_no_spurious_write: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(cfg_regs));

  // R8: soft reset bit restores all defaults
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == '0 && wr_data[0]) |=> cfg_regs == '0);

  // R9: status is sticky until reset
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    pd_init_done |=> pd_init_done);
endmodule

bind scfg_port scfg_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_s        (cs_s),
  .wr_stb      (wr_stb),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .bit_cnt     (bit_cnt),
  .cfg_regs    (cfg_regs),
  .pd_init_done(pd_init_done)
);

// File: tb/tb_scfg_port.sv
module tb_scfg_port;
  logic clk = 1'b0;
  logic rst, cs_n, sclk, sdata, pd_in;
  logic [255:0] cfg_regs;
  logic pd_init_done;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scfg_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .pd_in(pd_in), .cfg_regs(cfg_regs), .pd_init_done(pd_init_done)
  );

  function automatic logic [15:0] rd(int n);
    return cfg_regs[n*16 +: 16];
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdata = 1'b0; pd_in = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(4);
  endtask

  task automatic bit_out(logic b);
    sdata = b; sclk = 1'b0; idle(4);
    sclk = 1'b1; idle(4);
  endtask

  task automatic frame(logic [7:0] a, logic [15:0] d);
    logic [23:0] w;
    w = {a, d};
    for (int i = 23; i >= 0; i--) bit_out(w[i]);
  endtask

  task automatic sel(logic v);
    sclk = 1'b0; idle(3); cs_n = v; idle(3);
  endtask

  task automatic t_reset();
    chk("R1 regs", cfg_regs, '0);
    chk("R1 done", {255'b0, pd_init_done}, '0);
  endtask

  task automatic t_single_latency();
    logic [23:0] w;
    w = {8'h03, 16'hA5C3};
    sel(1'b0);
    for (int i = 23; i >= 1; i--) bit_out(w[i]);
    sdata = w[0]; sclk = 1'b0; idle(4);
    sclk = 1'b1;
    idle(3);
    chk("R11 not before 4th edge", rd(3), 16'h0000);
    idle(1);
    chk("R11 at 4th edge", rd(3), 16'hA5C3);
    idle(3);
    sel(1'b1);
    chk("R2 msb first addr 3", rd(3), 16'hA5C3);
    chk("R2 neighbours untouched", {rd(2), rd(4)}, '0);
  endtask

  task automatic t_multi();
    sel(1'b0);
    frame(8'h01, 16'h1111);
    frame(8'h02, 16'h2C2C);
    frame(8'h0E, 16'h8001);
    sel(1'b1);
    chk("R3 frame 1", rd(1), 16'h1111);
    chk("R3 frame 2", rd(2), 16'h2C2C);
    chk("R3 frame 3", rd(14), 16'h8001);
  endtask

  task automatic t_partial();
    logic [23:0] w;
    w = {8'h05, 16'hFFFF};
    sel(1'b0);
    frame(8'h04, 16'h4444);
    for (int i = 23; i >= 10; i--) bit_out(w[i]);
    sel(1'b1);
    chk("R4 full frame kept", rd(4), 16'h4444);
    chk("R4 leftover no write", rd(5), 16'h0000);
  endtask

  task automatic t_fresh();
    sel(1'b0);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    sel(1'b1);
    sel(1'b0);
    frame(8'h06, 16'h6A6A);
    sel(1'b1);
    chk("R6 fresh frame after select", rd(6), 16'h6A6A);
    chk("R6 no misaligned write", rd(7), 16'h0000);
  endtask

  task automatic t_cs_high();
    logic [255:0] snap;
    snap = cfg_regs;
    frame(8'h07, 16'h7777);
    idle(4);
    chk("R5 sclk ignored when deselected", cfg_regs, snap);
    sel(1'b0);
    frame(8'h08, 16'h0808);
    sel(1'b1);
    chk("R5 next frame clean", rd(8), 16'h0808);
  endtask

  task automatic t_unmapped();
    logic [255:0] snap;
    snap = cfg_regs;
    sel(1'b0);
    frame(8'h10, 16'hBEEF);
    frame(8'h83, 16'hDEAD);
    sel(1'b1);
    chk("R7 unmapped ignored", cfg_regs, snap);
  endtask

  task automatic t_soft_reset();
    sel(1'b0);
    frame(8'h00, 16'h00F0);
    sel(1'b1);
    chk("R8 bit0 clear stores", rd(0), 16'h00F0);
    sel(1'b0);
    frame(8'h09, 16'h1234);
    frame(8'h00, 16'h0001);
    sel(1'b1);
    chk("R8 soft reset defaults", cfg_regs, '0);
  endtask

  task automatic t_pd_reg();
    sel(1'b0);
    frame(8'h0F, 16'h0200);
    sel(1'b1);
    idle(4);
    chk("R9 pd bit set", rd(15), 16'h0200);
    chk("R9 high only not done", {255'b0, pd_init_done}, '0);
    sel(1'b0);
    frame(8'h0F, 16'h0000);
    sel(1'b1);
    idle(4);
    chk("R9 high then low done", {255'b0, pd_init_done}, 256'd1);
    sel(1'b0);
    frame(8'h0F, 16'h0200);
    sel(1'b1);
    idle(4);
    chk("R9 done stays", {255'b0, pd_init_done}, 256'd1);
  endtask

  task automatic t_pd_pin();
    do_reset();
    pd_in = 1'b1; idle(10);
    chk("R10 pin high not done", {255'b0, pd_init_done}, '0);
    pd_in = 1'b0; idle(8);
    chk("R10 pin pulse done", {255'b0, pd_init_done}, 256'd1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_single_latency();
    t_multi();
    t_partial();
    t_fresh();
    t_cs_high();
    t_unmapped();
    t_soft_reset();
    t_pd_reg();
    t_pd_pin();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule